// File: doc/BRIEF.md
# Configurable Lookup-Table Distributed RAM

This block models the memory mode of a logic cell whose two 4-input lookup tables (called here the F table and the G table, sixteen one-bit cells each) serve as read/write storage. A geometry input, held static during operation, arranges the 32 cells as two independent 16x1 memories, as one 32x1 memory, or as one 16x1 memory with a single write port and two read ports. A second static input picks the write timing. In level-sensitive timing the write enable itself is the write strobe. In edge-triggered timing, address, data and write enable are captured on the active edge of the write clock, and the enable acts as a clock enable. A third static input picks whether the rising or the falling clock edge is the active one.

Reads are combinational in every arrangement: the outputs follow the addressed cells with no clock involved. Reset loads every cell from the `INIT` parameter, where bit `i` holds F-table address `i` and bit `16+i` holds G-table address `i`. The static inputs are changed only while reset is asserted.

Top module: `lut_ram_cell`

## Requirements
- R1: While `rst_n` is low, and after it is released, F-table cell `a` holds `INIT[a]` and G-table cell `a` holds `INIT[16+a]` until a write changes it.
- R2: `f_out` and `g_out` follow a change of `f_addr`, `g_addr` or `d1` within the same clock period, without any write-clock edge.
- R3: With `geo_sel` = 0 or 3 (split), a write stores `d0` at F-table address `f_addr` and `d1` at G-table address `g_addr`, and `f_out` = F[`f_addr`], `g_out` = G[`g_addr`].
- R4: With `geo_sel` = 1 (wide), the cell index is {`d1`,`f_addr`}, with `d1` = 1 selecting the G table. A write stores `d0` there, `f_out` shows that cell and `g_out` is 0.
- R5: With `geo_sel` = 2 (dual-port), a write stores `d0` at address `f_addr` in both tables, `f_out` = F[`f_addr`] and `g_out` = G[`g_addr`], so `g_addr` reads independently of the write address.
- R6: With `edge_sel` = 1, the values of the address, data and `we` inputs at the active edge decide the write, and the new data shows on the outputs after that edge and not before it.
- R7: With `fall_sel` = 1, the falling edge of `clk` is the active write edge, for every geometry.
- R8: With `we` = 0, no cell changes in either timing mode, whatever the other inputs do.
- R9: With `edge_sel` = 0, a high `we` writes the addressed cell immediately, without any clock edge.
- R10: In dual-port mode, when `g_addr` equals the write address, `g_out` shows the old data before the active edge and the new data after it.
- R11: In edge-triggered mode, changing address or data inputs after the active edge does not alter the write that edge started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low reset, loads `INIT` into all cells |
| geo_sel | input | 2 | Geometry: 0 split, 1 wide, 2 dual-port, 3 split |
| edge_sel | input | 1 | 1 edge-triggered write, 0 level-sensitive write |
| fall_sel | input | 1 | 1 selects the falling clock edge as active |
| f_addr | input | AW | F-table address, also the write address in wide and dual-port modes |
| g_addr | input | AW | G-table address, the second read port in dual-port mode |
| d0 | input | 1 | Write data (F data in split mode) |
| d1 | input | 1 | G write data in split mode, top address bit in wide mode |
| we | input | 1 | Active-high write enable |
| f_out | output | 1 | F read output |
| g_out | output | 1 | G read output |

## Verification
On every active write edge the assertions check that an edge-triggered write lands in the right cell or cells for each geometry and that a low enable leaves both tables untouched. On every rising clock edge they check that a level-sensitive write has already reached its cell. Combinational reads, the old-then-new sequence of a dual-port read at the write address, falling-edge selection, preload values, and immunity to input changes after an edge appear only in the bench, whose model compares both outputs every period.

// File: rtl/lut_ram_pkg.sv
package lut_ram_pkg;

    localparam int TBL_AW    = 4;
    localparam int TBL_DEPTH = 1 << TBL_AW;
    localparam int ALL_CELLS = 2 * TBL_DEPTH;

    typedef enum logic [1:0] {
        GEO_SPLIT = 2'd0,
        GEO_WIDE  = 2'd1,
        GEO_DUAL  = 2'd2,
        GEO_ALT   = 2'd3
    } geo_e;

    typedef struct packed {
        logic [TBL_AW-1:0] fa;
        logic [TBL_AW-1:0] ga;
        logic              d0;
        logic              d1;
        logic              we;
    } wreq_t;

endpackage

// File: rtl/lut_ram_capture.sv
module lut_ram_capture
    import lut_ram_pkg::*;
(
    input  logic  wclk,
    input  logic  rst_n,
    input  wreq_t req_i,
    output wreq_t req_o
);

    typedef struct packed {
        wreq_t req;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = req_i;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;

endmodule

// File: rtl/lut_ram_decode.sv
module lut_ram_decode
    import lut_ram_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH
) (
    input  geo_e             geo,
    input  wreq_t            req,
    input  logic             strobe,
    output logic [DEPTH-1:0] f_en,
    output logic [DEPTH-1:0] g_en,
    output logic             f_wd,
    output logic             g_wd
);

    always_comb begin
        f_en = '0;
        g_en = '0;
        f_wd = req.d0;
        g_wd = req.d1;
        if (strobe) begin
            unique case (geo)
                GEO_WIDE: begin
                    g_wd = req.d0;
                    if (req.d1) g_en[req.fa] = 1'b1;
                    else        f_en[req.fa] = 1'b1;
                end
                GEO_DUAL: begin
                    g_wd          = req.d0;
                    f_en[req.fa]  = 1'b1;
                    g_en[req.fa]  = 1'b1;
                end
                default: begin
                    f_en[req.fa]  = 1'b1;
                    g_en[req.ga]  = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/lut_ram_table.sv
module lut_ram_table #(
    parameter int                 AW    = 4,
    parameter int                 DEPTH = 1 << AW,
    parameter logic [DEPTH-1:0]   PRELOAD = '0
) (
    input  logic             rst_n,
    input  logic [DEPTH-1:0] en,
    input  logic             wd,
    input  logic [AW-1:0]    raddr,
    output logic [DEPTH-1:0] cells,
    output logic             rd
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic bit_q;
        always_latch begin
            if (!rst_n) begin
                bit_q <= PRELOAD[i];
            end else if (en[i]) begin
                bit_q <= wd;
            end
        end
        assign cells[i] = bit_q;
    end

    assign rd = cells[raddr];

endmodule

// File: rtl/lut_ram_cell.sv
module lut_ram_cell
    import lut_ram_pkg::*;
#(
    parameter int                 AW    = TBL_AW,
    parameter logic [2*(1<<AW)-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    geo_sel,
    input  logic          edge_sel,
    input  logic          fall_sel,
    input  logic [AW-1:0] f_addr,
    input  logic [AW-1:0] g_addr,
    input  logic          d0,
    input  logic          d1,
    input  logic          we,
    output logic          f_out,
    output logic          g_out
);

    localparam int DEPTH = 1 << AW;

    geo_e             geo;
    logic             wclk;
    wreq_t            req_live, req_q, req_sel;
    logic             strobe;
    logic [DEPTH-1:0] f_en, g_en, f_cells, g_cells;
    logic             f_wd, g_wd, f_rd, g_rd;
    logic [AW-1:0]    g_raddr;

    typedef struct packed {
        logic f;
        logic g;
    } rd_t;
    rd_t rd_d;

    assign geo  = geo_e'(geo_sel);
    assign wclk = clk ^ fall_sel;

    assign req_live = '{fa: f_addr, ga: g_addr, d0: d0, d1: d1, we: we};

    lut_ram_capture u_cap (
        .wclk  (wclk),
        .rst_n (rst_n),
        .req_i (req_live),
        .req_o (req_q)
    );

    assign req_sel = edge_sel ? req_q : req_live;
    assign strobe  = edge_sel ? (req_q.we & wclk) : we;

    lut_ram_decode #(.DEPTH(DEPTH)) u_dec (
        .geo    (geo),
        .req    (req_sel),
        .strobe (strobe),
        .f_en   (f_en),
        .g_en   (g_en),
        .f_wd   (f_wd),
        .g_wd   (g_wd)
    );

    assign g_raddr = (geo == GEO_WIDE) ? f_addr : g_addr;

    lut_ram_table #(.AW(AW), .DEPTH(DEPTH), .PRELOAD(INIT[DEPTH-1:0])) u_ftab (
        .rst_n (rst_n),
        .en    (f_en),
        .wd    (f_wd),
        .raddr (f_addr),
        .cells (f_cells),
        .rd    (f_rd)
    );

    lut_ram_table #(.AW(AW), .DEPTH(DEPTH), .PRELOAD(INIT[2*DEPTH-1:DEPTH])) u_gtab (
        .rst_n (rst_n),
        .en    (g_en),
        .wd    (g_wd),
        .raddr (g_raddr),
        .cells (g_cells),
        .rd    (g_rd)
    );

    always_comb begin
        rd_d.f = f_rd;
        rd_d.g = g_rd;
        if (geo == GEO_WIDE) begin
            rd_d.f = d1 ? g_rd : f_rd;
            rd_d.g = 1'b0;
        end
    end

    assign f_out = rd_d.f;
    assign g_out = rd_d.g;

    // Edge-triggered split write reaches both tables (R6, R3)
    p_edge_write_r6: assert property (@(posedge wclk) disable iff (!rst_n)
        (rst_n && edge_sel && we && (geo == GEO_SPLIT || geo == GEO_ALT))
        |=> (f_cells[$past(f_addr)] == $past(d0)));

    p_split_g_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        (rst_n && edge_sel && we && (geo == GEO_SPLIT || geo == GEO_ALT))
        |=> (g_cells[$past(g_addr)] == $past(d1)));

    // Low enable at an active edge leaves every cell unchanged (R8)
    p_we_gate_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        (rst_n && edge_sel && !we)
        |=> ($stable(f_cells) && $stable(g_cells)));

    // Dual-port write updates both copies at the write address (R5)
    p_dual_copy_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        (rst_n && edge_sel && we && geo == GEO_DUAL)
        |=> (f_cells[$past(f_addr)] == $past(d0) && g_cells[$past(f_addr)] == $past(d0)));

    // Wide write lands in the half chosen by d1 (R4)
    p_wide_write_r4: assert property (@(posedge wclk) disable iff (!rst_n)
        (rst_n && edge_sel && we && geo == GEO_WIDE)
        |=> (($past(d1) ? g_cells[$past(f_addr)] : f_cells[$past(f_addr)]) == $past(d0)));

    // Level-sensitive write is already in the cell by the next clock (R9)
    p_level_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_sel && we && (geo == GEO_SPLIT || geo == GEO_ALT))
        |-> (f_cells[f_addr] == d0 && g_cells[g_addr] == d1));

endmodule

// File: tb/lut_ram_cell_tb.sv
module lut_ram_cell_tb;

    localparam logic [31:0] INIT_V = 32'h3C5A_96E1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] geo_sel = 2'd0;
    logic       edge_sel = 1'b1;
    logic       fall_sel = 1'b0;
    logic [3:0] f_addr = 4'd0;
    logic [3:0] g_addr = 4'd0;
    logic       d0 = 1'b0;
    logic       d1 = 1'b0;
    logic       we = 1'b0;
    logic       f_out, g_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic mf [16];
    logic mg [16];

    always #2 clk = ~clk;

    lut_ram_cell #(.AW(4), .INIT(INIT_V)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .geo_sel  (geo_sel),
        .edge_sel (edge_sel),
        .fall_sel (fall_sel),
        .f_addr   (f_addr),
        .g_addr   (g_addr),
        .d0       (d0),
        .d1       (d1),
        .we       (we),
        .f_out    (f_out),
        .g_out    (g_out)
    );

    task automatic mwrite(input logic [3:0] fa, input logic [3:0] ga, input logic a, input logic b);
        case (geo_sel)
            2'd1: if (b) mg[fa] = a; else mf[fa] = a;
            2'd2: begin mf[fa] = a; mg[fa] = a; end
            default: begin mf[fa] = a; mg[ga] = b; end
        endcase
    endtask

    always @(posedge clk) if (rst_n && edge_sel && !fall_sel && we) mwrite(f_addr, g_addr, d0, d1);
    always @(negedge clk) if (rst_n && edge_sel &&  fall_sel && we) mwrite(f_addr, g_addr, d0, d1);

    task automatic check(input string tag);
        logic ef, eg;
        ef = (geo_sel == 2'd1) ? (d1 ? mg[f_addr] : mf[f_addr]) : mf[f_addr];
        eg = (geo_sel == 2'd1) ? 1'b0 : mg[g_addr];
        n_chk++;
        if (f_out !== ef || g_out !== eg) begin
            n_fail++;
            $display("FAIL %s: f_out=%b g_out=%b expected f_out=%b g_out=%b (geo=%0d fa=%0d ga=%0d)",
                     tag, f_out, g_out, ef, eg, geo_sel, f_addr, g_addr);
        end
    endtask

    task automatic cyc(input logic [3:0] fa, input logic [3:0] ga, input logic a,
                       input logic b, input logic w, input string tag);
        @(posedge clk);
        #1;
        f_addr = fa; g_addr = ga; d0 = a; d1 = b; we = w;
        #2;
        if (!edge_sel && w) mwrite(fa, ga, a, b);
        check(tag);
    endtask

    task automatic reconfig(input logic [1:0] g, input logic e, input logic f);
        @(posedge clk);
        #1;
        rst_n = 1'b0; we = 1'b0;
        geo_sel = g; edge_sel = e; fall_sel = f;
        #4;
        for (int a = 0; a < 16; a++) begin
            mf[a] = INIT_V[a];
            mg[a] = INIT_V[16+a];
        end
        #2;
        check("R1");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    initial begin
        // R1: preload after reset, split edge rising
        reconfig(2'd0, 1'b1, 1'b0);
        for (int a = 0; a < 16; a++) cyc(4'(a), 4'(15 - a), 1'b0, 1'b0, 1'b0, "R1");

        // R6, R3: edge-triggered split writes, visible only after the edge
        for (int i = 0; i < 12; i++)
            cyc(4'(i * 5), 4'(i * 7 + 3), i[0], ~i[1], (i % 3) != 2, "R6");
        for (int a = 0; a < 16; a++) cyc(4'(a), 4'(a + 9), 1'b0, 1'b0, 1'b0, "R3");

        // R11: inputs change right after the edge that starts a write
        cyc(4'd2, 4'd13, ~mf[2], ~mg[13], 1'b1, "R11");
        cyc(4'd7, 4'd1, 1'b1, 1'b1, 1'b0, "R11");
        cyc(4'd2, 4'd13, 1'b0, 1'b0, 1'b0, "R11");

        // R8: edge mode, we low with moving data and addresses
        for (int i = 0; i < 8; i++) cyc(4'(i * 3), 4'(i * 11), ~i[0], i[0], 1'b0, "R8");

        // R3: geometry code 3 behaves as split
        reconfig(2'd3, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) cyc(4'(i * 9), 4'(i * 2), ~i[1], i[0], 1'b1, "R3");
        for (int a = 0; a < 16; a++) cyc(4'(a), 4'(a), 1'b0, 1'b0, 1'b0, "R3");

        // R7: falling active edge
        reconfig(2'd0, 1'b1, 1'b1);
        for (int i = 0; i < 10; i++) cyc(4'(i * 3 + 1), 4'(i * 5), i[0], ~i[0], 1'b1, "R7");
        for (int a = 0; a < 16; a++) cyc(4'(a), 4'(a * 3), 1'b0, 1'b0, 1'b0, "R7");

        // R4: wide 32x1, d1 is the top address bit
        reconfig(2'd1, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) cyc(4'(i * 7), 4'd0, ~i[0], i[1], 1'b1, "R4");
        for (int a = 0; a < 32; a++) cyc(4'(a), 4'(a), 1'b0, a[4], 1'b0, "R4");

        // R10: dual-port read at the write address, old then new
        reconfig(2'd2, 1'b1, 1'b0);
        cyc(4'd6, 4'd6, ~INIT_V[22], 1'b0, 1'b1, "R10");
        cyc(4'd6, 4'd6, 1'b0, 1'b0, 1'b0, "R10");
        cyc(4'd9, 4'd9, ~INIT_V[25], 1'b0, 1'b1, "R10");
        cyc(4'd9, 4'd9, 1'b0, 1'b0, 1'b0, "R10");

        // R5: dual-port writes with an independent read address
        for (int i = 0; i < 12; i++) cyc(4'(i * 5 + 2), 4'(i * 3), i[1], 1'b0, 1'b1, "R5");
        for (int a = 0; a < 16; a++) cyc(4'(a), 4'(15 - a), 1'b0, 1'b0, 1'b0, "R5");

        // R9: level-sensitive writes, no edge needed
        reconfig(2'd0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            cyc(4'(i * 5), 4'(i * 3 + 1), ~i[0], i[1], 1'b1, "R9");
            cyc(4'(i * 5), 4'(i * 3 + 1), ~i[0], i[1], 1'b0, "R9");
        end

        // R8: level mode, we low with moving data
        for (int i = 0; i < 8; i++) cyc(4'(i * 5), 4'(i * 3 + 1), i[0], ~i[0], 1'b0, "R8");

        // R2: combinational read as addresses move each period
        for (int a = 0; a < 16; a++) cyc(4'(a), 4'(a ^ 4'hA), 1'b0, 1'b0, 1'b0, "R2");

        summary();
    end

endmodule